// File: doc/BRIEF.md
# Alarm Indicator and Silence Controller

This block takes one alarm request line for each of three severities: critical, major and minor. It latches each request and drives a lamp and a relay for each severity. A single front-panel push button is synchronised and debounced. A short press puts the block into a silence mode, and another short press takes it out. In silence mode every relay is released and every lit lamp flashes, but no latched alarm is lost. Holding the same button for a long time produces a one-cycle module reset request instead of a toggle.

Latched alarms are removed only by the clear inputs. The major and minor severities each have an active-low clear, and a separate clear-all input removes every severity, including critical. When the last active alarm is cleared, silence mode ends by itself. A later alarm therefore drives its relay again without any action on the button.

The debounce window, the long-press threshold and the flash half-period are parameters counted in clock cycles. The defaults give 20 ms, 5 s and a 1 Hz flash at a 200 MHz clock.

Top module: `alarm_silence_ctrl`

## Requirements
- R1: A request bit that is high at a clock edge makes its severity active from the next cycle. The severity then stays active after the request drops, until a clear removes it. Severity bit order is 0 = minor, 1 = major, 2 = critical.
- R2: After reset no severity is active: lamp_on = 000, lamp_flash = 000, relay_n = 111 and reset_req = 0. An active severity outside silence mode gives lamp_on = 1, lamp_flash = 0 and relay_n = 0.
- R3: In silence mode every active severity has lamp_flash = 1 and relay_n = 1. Its lamp_on follows a square wave with FLASH_HALF_CYC cycles high and FLASH_HALF_CYC cycles low.
- R4: The button passes through a two-flop synchroniser and is accepted only after it has differed from the debounced level for DEBOUNCE_CYC consecutive cycles. A shorter pulse has no effect.
- R5: A debounced press released before LONG_CYC pressed cycles toggles silence mode on release. A press never clears an alarm. With no active alarm, the toggle has no effect.
- R6: A debounced press held for LONG_CYC cycles gives exactly one reset_req pulse, one cycle wide. Releasing the button after that does not toggle silence mode.
- R7: clr_major_n low at an edge clears major, and clr_minor_n low clears minor. Neither affects critical. A clear wins over a request to the same severity in the same cycle.
- R8: clr_all high at an edge clears all three severities.
- R9: When no severity remains active, silence mode ends. An alarm raised afterwards drives steady lamp_on = 1 and relay_n = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm_req | input | 3 | Alarm request per severity (0 minor, 1 major, 2 critical) |
| clr_major_n | input | 1 | Active-low clear of the major alarm |
| clr_minor_n | input | 1 | Active-low clear of the minor alarm |
| clr_all | input | 1 | Active-high clear of every severity |
| button | input | 1 | Raw push button, high while pressed |
| lamp_on | output | 3 | Lamp drive per severity, high = lit |
| lamp_flash | output | 3 | High while the severity is active and flashing in silence mode |
| relay_n | output | 3 | Active-low relay drive per severity |
| reset_req | output | 1 | One-cycle module reset request after a long press |

## Verification
The bench sends a two-cycle button glitch, which must leave silence mode unchanged. A debouncer that passes short pulses would toggle the mode and release the critical relay. A long hold must produce exactly one reset pulse, within the expected window, and no toggle on release. A design that pulses on every cycle of the hold, or that also toggles on release, would show a second pulse or flashing lamps. Clears are applied together with a request to the same severity and with critical active. A design that gives the request priority, or that lets a partial clear reach critical, would leave the wrong lamps lit. A design without the auto-exit would keep a fresh alarm silenced after clear-all, and a press made with no alarm active must not silence a later alarm.

// File: rtl/alarm_silence_pkg.sv
package alarm_silence_pkg;

    localparam int NUM_SEV   = 3;
    localparam int SEV_MINOR = 0;
    localparam int SEV_MAJOR = 1;
    localparam int SEV_CRIT  = 2;

    typedef logic [NUM_SEV-1:0] sev_vec_t;

    typedef struct packed {
        logic toggle;    // short press released
        logic long_hit;  // long press threshold reached
    } btn_evt_t;

    // Build the per-severity clear mask from the clear inputs.
    function automatic sev_vec_t clear_mask(input logic major_n,
                                            input logic minor_n,
                                            input logic all_hi);
        sev_vec_t m;
        m            = '0;
        m[SEV_MAJOR] = ~major_n;
        m[SEV_MINOR] = ~minor_n;
        if (all_hi) m = '1;
        return m;
    endfunction

endpackage

// File: rtl/asc_button.sv
module asc_button
    import alarm_silence_pkg::*;
#(
    parameter int DEBOUNCE_CYC = 4_000_000,
    parameter int LONG_CYC     = 1_000_000_000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     button,
    output btn_evt_t evt
);
    localparam int DEB_W = $clog2(DEBOUNCE_CYC + 1);
    localparam int HLD_W = $clog2(LONG_CYC + 1);
    localparam logic [DEB_W-1:0] DEB_LAST  = DEB_W'(DEBOUNCE_CYC - 1);
    localparam logic [HLD_W-1:0] HLD_LAST  = HLD_W'(LONG_CYC - 1);
    localparam logic [HLD_W-1:0] HLD_FULL  = HLD_W'(LONG_CYC);

    logic             sync1_q, sync2_q;
    logic             deb_q;
    logic [DEB_W-1:0] deb_cnt_q;
    logic [HLD_W-1:0] hold_q;
    logic             flip;

    assign flip = (sync2_q != deb_q) && (deb_cnt_q == DEB_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= button;
            sync2_q <= sync1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            deb_q     <= 1'b0;
            deb_cnt_q <= '0;
        end else if (sync2_q != deb_q) begin
            if (flip) begin
                deb_q     <= sync2_q;
                deb_cnt_q <= '0;
            end else begin
                deb_cnt_q <= deb_cnt_q + 1'b1;
            end
        end else begin
            deb_cnt_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            evt    <= '0;
        end else begin
            evt.long_hit <= deb_q && (hold_q == HLD_LAST);
            evt.toggle   <= deb_q && flip && (hold_q != HLD_FULL);
            if (!deb_q)
                hold_q <= '0;
            else if (hold_q != HLD_FULL)
                hold_q <= hold_q + 1'b1;
        end
    end

endmodule

// File: rtl/asc_flash.sv
module asc_flash #(
    parameter int FLASH_HALF_CYC = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);
    localparam int FW = $clog2(FLASH_HALF_CYC + 1);
    localparam logic [FW-1:0] F_LAST = FW'(FLASH_HALF_CYC - 1);

    logic [FW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            phase <= 1'b1;
        end else if (cnt_q == F_LAST) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/asc_sev_latch.sv
module asc_sev_latch
    import alarm_silence_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sev_vec_t req,
    input  sev_vec_t clr,
    output sev_vec_t active_d,
    output sev_vec_t active_q
);
    for (genvar s = 0; s < NUM_SEV; s++) begin : g_sev
        // clear takes priority over a same-cycle request
        assign active_d[s] = clr[s] ? 1'b0 : (active_q[s] | req[s]);

        always_ff @(posedge clk) begin
            if (rst) active_q[s] <= 1'b0;
            else     active_q[s] <= active_d[s];
        end
    end

endmodule

// File: rtl/alarm_silence_ctrl.sv
module alarm_silence_ctrl
    import alarm_silence_pkg::*;
#(
    parameter int DEBOUNCE_CYC   = 4_000_000,
    parameter int LONG_CYC       = 1_000_000_000,
    parameter int FLASH_HALF_CYC = 100_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] alarm_req,
    input  logic       clr_major_n,
    input  logic       clr_minor_n,
    input  logic       clr_all,
    input  logic       button,
    output logic [2:0] lamp_on,
    output logic [2:0] lamp_flash,
    output logic [2:0] relay_n,
    output logic       reset_req
);
    btn_evt_t evt;
    sev_vec_t clr, act_d, act_q, steady;
    logic     phase;
    logic     silence_q;

    asc_button #(
        .DEBOUNCE_CYC(DEBOUNCE_CYC),
        .LONG_CYC    (LONG_CYC)
    ) u_button (
        .clk   (clk),
        .rst   (rst),
        .button(button),
        .evt   (evt)
    );

    asc_flash #(
        .FLASH_HALF_CYC(FLASH_HALF_CYC)
    ) u_flash (
        .clk  (clk),
        .rst  (rst),
        .phase(phase)
    );

    assign clr = clear_mask(clr_major_n, clr_minor_n, clr_all);

    asc_sev_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .req     (alarm_req),
        .clr     (clr),
        .active_d(act_d),
        .active_q(act_q)
    );

    // silence mode leaves as soon as nothing remains active
    always_ff @(posedge clk) begin
        if (rst)              silence_q <= 1'b0;
        else if (act_d == '0) silence_q <= 1'b0;
        else                  silence_q <= silence_q ^ evt.toggle;
    end

    assign steady     = silence_q ? '0 : act_q;
    assign lamp_flash = silence_q ? act_q : '0;
    assign lamp_on    = steady | (lamp_flash & {NUM_SEV{phase}});
    assign relay_n    = ~steady;
    assign reset_req  = evt.long_hit;

endmodule

// File: rtl/alarm_silence_chk.sv
module alarm_silence_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] alarm_req,
    input logic       clr_major_n,
    input logic       clr_minor_n,
    input logic       clr_all,
    input logic [2:0] lamp_flash,
    input logic [2:0] relay_n,
    input logic       reset_req
);
    logic [2:0] act;
    assign act = lamp_flash | ~relay_n;

    a_r1_latch_hold: assert property (@(posedge clk) disable iff (rst)
        (clr_major_n && clr_minor_n && !clr_all)
        |=> ((($past(act) | $past(alarm_req)) & ~act) == 3'b000));

    a_r3_silence_relay: assert property (@(posedge clk) disable iff (rst)
        ((lamp_flash & ~relay_n) == 3'b000));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    a_r7_major_clear: assert property (@(posedge clk) disable iff (rst)
        !clr_major_n |=> !act[1]);

    a_r7_minor_clear: assert property (@(posedge clk) disable iff (rst)
        !clr_minor_n |=> !act[0]);

    a_r8_clear_all: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (act == 3'b000));

endmodule

bind alarm_silence_ctrl alarm_silence_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .alarm_req  (alarm_req),
    .clr_major_n(clr_major_n),
    .clr_minor_n(clr_minor_n),
    .clr_all    (clr_all),
    .lamp_flash (lamp_flash),
    .relay_n    (relay_n),
    .reset_req  (reset_req)
);

// File: tb/alarm_silence_ctrl_tb.sv
`timescale 1ns/1ps
module alarm_silence_ctrl_tb;

    localparam int DEB  = 4;
    localparam int LONG = 40;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] alarm_req = '0;
    logic       clr_major_n = 1'b1;
    logic       clr_minor_n = 1'b1;
    logic       clr_all = 1'b0;
    logic       button = 1'b0;
    logic [2:0] lamp_on, lamp_flash, relay_n;
    logic       reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic [2:0] on;
        logic [2:0] on_mask;
        logic [2:0] flash;
        logic [2:0] rel;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    alarm_silence_ctrl #(
        .DEBOUNCE_CYC  (DEB),
        .LONG_CYC      (LONG),
        .FLASH_HALF_CYC(HALF)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .alarm_req  (alarm_req),
        .clr_major_n(clr_major_n),
        .clr_minor_n(clr_minor_n),
        .clr_all    (clr_all),
        .button     (button),
        .lamp_on    (lamp_on),
        .lamp_flash (lamp_flash),
        .relay_n    (relay_n),
        .reset_req  (reset_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare queued expectations just after each clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " lamp_on"},    32'(lamp_on & e.on_mask), 32'(e.on & e.on_mask));
                check({e.tag, " lamp_flash"}, 32'(lamp_flash), 32'(e.flash));
                check({e.tag, " relay_n"},    32'(relay_n), 32'(e.rel));
            end
        end
    end

    // driver: queue an expectation for after the next edge, then step
    task automatic expect_next(input string tag, input logic [2:0] on,
                               input logic [2:0] mask, input logic [2:0] fl,
                               input logic [2:0] rel);
        exp_t e;
        e.tag = tag; e.on = on; e.on_mask = mask; e.flash = fl; e.rel = rel;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic press(input int n);
        button = 1'b1;
        idle(n);
        button = 1'b0;
        idle(14);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ones;
        int pulses;
        int first;
        idle(4);
        rst = 1'b0;
        expect_next("R2 reset state", 3'b000, 3'b111, 3'b000, 3'b111);
        check("R2 reset_req idle", 32'(reset_req), 32'd0);

        // R1 latch on a single-cycle request
        alarm_req = 3'b100;
        expect_next("R1 critical set", 3'b100, 3'b111, 3'b000, 3'b011);
        alarm_req = 3'b000;
        expect_next("R1 critical held", 3'b100, 3'b111, 3'b000, 3'b011);

        // R7 clear wins over a same-cycle request, critical unaffected
        alarm_req = 3'b010;
        expect_next("R2 major steady", 3'b110, 3'b111, 3'b000, 3'b001);
        clr_major_n = 1'b0;
        expect_next("R7 major clear beats request", 3'b100, 3'b111, 3'b000, 3'b011);
        clr_major_n = 1'b1;
        alarm_req = 3'b001;
        expect_next("R1 minor set", 3'b101, 3'b111, 3'b000, 3'b010);
        alarm_req = 3'b000;
        clr_minor_n = 1'b0;
        expect_next("R7 minor clear keeps critical", 3'b100, 3'b111, 3'b000, 3'b011);
        clr_minor_n = 1'b1;

        // R4 short glitch ignored
        press(2);
        idle(10);
        expect_next("R4 glitch ignored", 3'b100, 3'b111, 3'b000, 3'b011);

        // R5 short press enters silence, alarm kept
        press(15);
        expect_next("R5 silence entered, alarm kept", 3'b000, 3'b000, 3'b100, 3'b111);

        // R3 50 percent flash over four full periods
        ones = 0;
        for (int i = 0; i < 8 * HALF; i++) begin
            @(negedge clk);
            if (lamp_on[2]) ones++;
        end
        check("R3 flash duty", 32'(ones), 32'(4 * HALF));

        // R3 a new alarm during silence also flashes, relay released
        alarm_req = 3'b001;
        expect_next("R3 new alarm in silence", 3'b000, 3'b000, 3'b101, 3'b111);
        alarm_req = 3'b000;
        press(15);
        expect_next("R5 silence left by second press", 3'b101, 3'b111, 3'b000, 3'b010);

        // R6 long press: one pulse, no toggle
        pulses = 0;
        first = -1;
        button = 1'b1;
        for (int i = 1; i <= 70; i++) begin
            @(negedge clk);
            if (reset_req) begin
                pulses++;
                if (first < 0) first = i;
            end
        end
        button = 1'b0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (reset_req) pulses++;
        end
        check("R6 reset pulse count", 32'(pulses), 32'd1);
        check("R6 pulse after threshold", 32'(first >= LONG && first <= LONG + DEB + 4), 32'd1);
        expect_next("R6 no toggle after long press", 3'b101, 3'b111, 3'b000, 3'b010);

        // R8 and R9: clear-all in silence, then a fresh alarm drives relay
        press(15);
        expect_next("R5 silence again", 3'b000, 3'b000, 3'b101, 3'b111);
        clr_all = 1'b1;
        expect_next("R8 clear all", 3'b000, 3'b111, 3'b000, 3'b111);
        clr_all = 1'b0;
        alarm_req = 3'b100;
        expect_next("R9 fresh alarm after auto exit", 3'b100, 3'b111, 3'b000, 3'b011);
        alarm_req = 3'b000;

        // R5 press with nothing active has no effect
        clr_all = 1'b1;
        expect_next("R8 clear critical", 3'b000, 3'b111, 3'b000, 3'b111);
        clr_all = 1'b0;
        press(15);
        alarm_req = 3'b010;
        expect_next("R5 idle press ignored", 3'b010, 3'b111, 3'b000, 3'b101);
        alarm_req = 3'b000;

        idle(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule